// File: doc/BRIEF.md
# CCD Vertical Frame Sequencer

This block drives the four-phase vertical clocks of a frame-transfer CCD. It generates one 4-bit clock vector for the image section and one for the storage section. A line counter advances on every line strobe from the horizontal timing generator, and the counter wraps at a frame length that depends on the mode.

In still mode, the sequencer performs one line shift per line time. The shift starts inside the horizontal blanking window, at a programmed blanking phase, and on it the image and storage clocks step together. In monitor mode, the sequencer performs a fast frame shift instead. This is a burst of back-to-back line shifts at the transport rate, which is one shift per 16 pixel clocks (about 1.56 MHz at a 25 MHz pixel clock). During the burst the storage clocks follow only selected image shifts, so the active region is subsampled two lines in ten.

A charge-reset pulse starts integration on a programmable line of the frame. A one-cycle flag marks the start of each frame. The mode select and the charge-reset line are both sampled only when a frame begins.

Top module: `ccd_vert_seq`

## Requirements
- R1: While reset is high and after it is released, before any line strobe, `a_ph` and `b_ph` both hold the idle pattern 4'b0011 (bit 0 is phase 1), and `cr_pulse` and `frame_start` are low.
- R2: The first line strobe after reset starts a frame. A frame lasts STILL_LEN (2035) strobes in still mode and MON_LEN (315) strobes in monitor mode. The next strobe then starts a new frame. `frame_start` is high for exactly the one cycle after each frame-starting strobe.
- R3: In still mode (`mode_sel` = 0), each of lines 1 to IMG_LINES+STORE_LINES (1622) performs exactly one line shift, and no other line shifts. The shift begins in the cycle after the one in which `blank_win` is high and `blank_phase` equals SHIFT_AT (2). That match must come at least two cycles after the line strobe. The storage clocks step with every image shift.
- R4: A line shift lasts DIV (16) clocks, split into four equal quarters showing 4'b0110, 4'b1100, 4'b1001 and 4'b0011. At every cycle, exactly two adjacent phases of each clock vector are high.
- R5: In monitor mode (`mode_sel` = 1), each frame starts a frame shift of exactly IMG_LINES (1324) image shifts. Consecutive shifts start exactly DIV clocks apart, and the shifts do not depend on blanking.
- R6: Within a frame shift, number the image shifts i = 0 to 1323. The storage clocks step together with shift i when i < HEAD_LINES (16), or when i is below HEAD_LINES plus the 1290 subsampled lines and (i-16) mod 10 < 2. The subsampled region therefore keeps 258 lines. On the last TAIL_LINES (18) shifts and on every skipped shift, `b_ph` stays at 4'b0011.
- R7: `cr_pulse` is high for CR_LEN (32) cycles. The pulse starts in the cycle after the strobe of the frame line whose index equals the latched `cr_line`, where index 0 is the frame-starting strobe.
- R8: `mode_sel` and `cr_line` are sampled only on a frame-starting strobe. Changing either of them in the middle of a frame does not affect that frame's length, its shifts or its charge-reset line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_strobe | input | 1 | One-cycle pulse at the start of each line |
| blank_win | input | 1 | High during horizontal blanking |
| blank_phase | input | PW | Position inside the blanking window |
| mode_sel | input | 1 | 0 = still, 1 = monitor |
| cr_line | input | LW | Frame line that fires the charge-reset pulse |
| a_ph | output | 4 | Image-section clock phases, bit 0 = phase 1 |
| b_ph | output | 4 | Storage-section clock phases, bit 0 = phase 1 |
| cr_pulse | output | 1 | Charge-reset pulse that starts integration |
| frame_start | output | 1 | One-cycle frame-start flag |

## Verification
The bench runs one still frame using short lines, then two monitor frames using long lines. This separates the blanking-triggered single shift from the free-running burst, and it separates the two frame lengths. A mode change and a new charge-reset line are applied in the middle of the still frame, and a further change in the middle of a monitor frame. These show whether the sampling happens at the frame boundary or immediately. Counting the image shifts separately from the storage shifts, together with the storage pattern by shift index, distinguishes full transfer from 2-in-10 subsampling and from a misplaced group boundary. Measuring the spacing between shifts and the length of each quarter distinguishes a chained transport from a shift that loses cycles between steps.

// File: rtl/vseq_pkg.sv
`timescale 1ns/1ps
package vseq_pkg;

    typedef enum logic {
        MODE_STILL   = 1'b0,
        MODE_MONITOR = 1'b1
    } vmode_e;

    // Rest state of a four-phase vector: phases 1 and 2 high.
    localparam logic [3:0] PH_IDLE = 4'b0011;

    typedef struct packed {
        logic go;      // request one line shift
        logic keep_b;  // storage clocks follow this shift
    } shift_req_t;

    function automatic logic [3:0] ph_rotl(input logic [3:0] v, input logic [1:0] n);
        logic [7:0] d;
        d = {v, v} << n;
        return d[7:4];
    endfunction

endpackage

// File: rtl/vseq_phase_gen.sv
`timescale 1ns/1ps
module vseq_phase_gen
    import vseq_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  shift_req_t req,
    output logic       ready,
    output logic [3:0] a_ph,
    output logic [3:0] b_ph
);
    localparam int QLEN = DIV / 4;
    localparam int SW   = (QLEN > 1) ? $clog2(QLEN) : 1;

    logic          busy;
    logic          keep_q;
    logic [1:0]    qtr;
    logic [SW-1:0] sub;
    logic          last;
    logic [3:0]    step_pat;

    assign last  = busy && (qtr == 2'd3) && (sub == SW'(QLEN - 1));
    // A new shift may be chained onto the final cycle of the current one.
    assign ready = !busy || last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            keep_q <= 1'b0;
            qtr    <= 2'd0;
            sub    <= '0;
        end else if (req.go && ready) begin
            busy   <= 1'b1;
            keep_q <= req.keep_b;
            qtr    <= 2'd0;
            sub    <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
            end else if (sub == SW'(QLEN - 1)) begin
                sub <= '0;
                qtr <= qtr + 2'd1;
            end else begin
                sub <= sub + SW'(1);
            end
        end
    end

    assign step_pat = ph_rotl(PH_IDLE, qtr + 2'd1);
    assign a_ph     = busy ? step_pat : PH_IDLE;
    assign b_ph     = (busy && keep_q) ? step_pat : PH_IDLE;

endmodule

// File: rtl/vseq_line_ctr.sv
`timescale 1ns/1ps
module vseq_line_ctr
    import vseq_pkg::*;
#(
    parameter int STILL_LEN = 2035,
    parameter int MON_LEN   = 315,
    parameter int CR_LEN    = 32,
    parameter int LW        = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_strobe,
    input  vmode_e        mode_sel,
    input  logic [LW-1:0] cr_line,
    output logic [LW-1:0] line_q,
    output vmode_e        mode_q,
    output logic          frame_start,
    output logic          line_tick,
    output logic          cr_pulse
);
    localparam int CRW = $clog2(CR_LEN + 1);

    logic           fresh;
    logic [LW-1:0]  cr_lat;
    logic [LW-1:0]  last_line;
    logic [CRW-1:0] cr_cnt;
    logic           wrap;
    logic           cr_hit;

    assign last_line = (mode_q == MODE_STILL) ? LW'(STILL_LEN - 1) : LW'(MON_LEN - 1);
    assign wrap      = fresh || (line_q == last_line);
    assign cr_hit    = line_strobe &&
                       (wrap ? (cr_line == '0) : ((line_q + LW'(1)) == cr_lat));

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh       <= 1'b1;
            line_q      <= '0;
            mode_q      <= MODE_STILL;
            cr_lat      <= '0;
            frame_start <= 1'b0;
            line_tick   <= 1'b0;
            cr_cnt      <= '0;
        end else begin
            frame_start <= line_strobe && wrap;
            line_tick   <= line_strobe;
            if (line_strobe) begin
                if (wrap) begin
                    line_q <= '0;
                    mode_q <= mode_sel;
                    cr_lat <= cr_line;
                    fresh  <= 1'b0;
                end else begin
                    line_q <= line_q + LW'(1);
                end
            end
            if (cr_hit) begin
                cr_cnt <= CRW'(CR_LEN);
            end else if (cr_cnt != '0) begin
                cr_cnt <= cr_cnt - CRW'(1);
            end
        end
    end

    assign cr_pulse = (cr_cnt != '0);

endmodule

// File: rtl/vseq_subsample.sv
`timescale 1ns/1ps
module vseq_subsample #(
    parameter int IMG_LINES  = 1324,
    parameter int HEAD_LINES = 16,
    parameter int TAIL_LINES = 18,
    parameter int GROUP      = 10,
    parameter int KEEP       = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic begin_fs,
    input  logic accept,
    output logic active,
    output logic keep_b
);
    localparam int SUB_LINES = IMG_LINES - HEAD_LINES - TAIL_LINES;
    localparam int IW        = $clog2(IMG_LINES + 1);
    localparam int GW        = (GROUP > 1) ? $clog2(GROUP) : 1;

    logic [IW-1:0] idx;
    logic [GW-1:0] grp;

    assign keep_b = (idx < IW'(HEAD_LINES)) ||
                    ((idx < IW'(HEAD_LINES + SUB_LINES)) && (grp < GW'(KEEP)));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            grp    <= '0;
        end else if (begin_fs) begin
            active <= 1'b1;
            idx    <= '0;
            grp    <= '0;
        end else if (accept && active) begin
            if (idx == IW'(IMG_LINES - 1)) begin
                active <= 1'b0;
            end
            idx <= idx + IW'(1);
            if (idx >= IW'(HEAD_LINES)) begin
                grp <= (grp == GW'(GROUP - 1)) ? '0 : grp + GW'(1);
            end
        end
    end

endmodule

// File: rtl/ccd_vert_seq.sv
`timescale 1ns/1ps
module ccd_vert_seq
    import vseq_pkg::*;
#(
    parameter int DIV         = 16,
    parameter int IMG_LINES   = 1324,
    parameter int STORE_LINES = 298,
    parameter int HEAD_LINES  = 16,
    parameter int TAIL_LINES  = 18,
    parameter int GROUP       = 10,
    parameter int KEEP        = 2,
    parameter int STILL_LEN   = 2035,
    parameter int MON_LEN     = 315,
    parameter int CR_LEN      = 32,
    parameter int PW          = 8,
    parameter int SHIFT_AT    = 2,
    localparam int LW = $clog2((STILL_LEN > MON_LEN) ? STILL_LEN : MON_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_strobe,
    input  logic          blank_win,
    input  logic [PW-1:0] blank_phase,
    input  logic          mode_sel,
    input  logic [LW-1:0] cr_line,
    output logic [3:0]    a_ph,
    output logic [3:0]    b_ph,
    output logic          cr_pulse,
    output logic          frame_start
);
    localparam int STILL_SHIFTS = IMG_LINES + STORE_LINES;

    logic [LW-1:0] line_q;
    vmode_e        mode_q;
    logic          line_tick;
    logic          tr_ready;
    logic          fs_active;
    logic          sub_keep;
    logic          still_pend;
    logic          still_go;
    logic          in_range;
    logic          accept;
    shift_req_t    req;

    vseq_line_ctr #(
        .STILL_LEN (STILL_LEN),
        .MON_LEN   (MON_LEN),
        .CR_LEN    (CR_LEN),
        .LW        (LW)
    ) u_line (
        .clk         (clk),
        .rst         (rst),
        .line_strobe (line_strobe),
        .mode_sel    (vmode_e'(mode_sel)),
        .cr_line     (cr_line),
        .line_q      (line_q),
        .mode_q      (mode_q),
        .frame_start (frame_start),
        .line_tick   (line_tick),
        .cr_pulse    (cr_pulse)
    );

    vseq_subsample #(
        .IMG_LINES  (IMG_LINES),
        .HEAD_LINES (HEAD_LINES),
        .TAIL_LINES (TAIL_LINES),
        .GROUP      (GROUP),
        .KEEP       (KEEP)
    ) u_sub (
        .clk      (clk),
        .rst      (rst),
        .begin_fs (frame_start && (mode_q == MODE_MONITOR)),
        .accept   (accept && (mode_q == MODE_MONITOR)),
        .active   (fs_active),
        .keep_b   (sub_keep)
    );

    // Still mode: one shift per line in the transfer range, placed in blanking.
    assign in_range = (line_q != '0) && (line_q <= LW'(STILL_SHIFTS));
    assign still_go = still_pend && blank_win && (blank_phase == PW'(SHIFT_AT));

    always_ff @(posedge clk) begin
        if (rst) begin
            still_pend <= 1'b0;
        end else if (line_tick) begin
            still_pend <= (mode_q == MODE_STILL) && in_range;
        end else if (still_go && tr_ready) begin
            still_pend <= 1'b0;
        end
    end

    always_comb begin
        if (mode_q == MODE_MONITOR) begin
            req.go     = fs_active;
            req.keep_b = sub_keep;
        end else begin
            req.go     = still_go;
            req.keep_b = 1'b1;
        end
    end

    assign accept = req.go && tr_ready;

    vseq_phase_gen #(
        .DIV (DIV)
    ) u_phase (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .ready (tr_ready),
        .a_ph  (a_ph),
        .b_ph  (b_ph)
    );

endmodule

// File: rtl/vseq_checker.sv
`timescale 1ns/1ps
module vseq_checker
    import vseq_pkg::*;
#(
    parameter int PW       = 8,
    parameter int SHIFT_AT = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          line_strobe,
    input logic          blank_win,
    input logic [PW-1:0] blank_phase,
    input logic [3:0]    a_ph,
    input logic [3:0]    b_ph,
    input logic          cr_pulse,
    input logic          frame_start,
    input vmode_e        mode_q
);

    assert_a_legal_R4: assert property (@(posedge clk) disable iff (rst)
        (a_ph inside {4'b0011, 4'b0110, 4'b1100, 4'b1001}))
        else $error("image phases not two adjacent high");

    assert_b_legal_R4: assert property (@(posedge clk) disable iff (rst)
        (b_ph inside {4'b0011, 4'b0110, 4'b1100, 4'b1001}))
        else $error("storage phases not two adjacent high");

    assert_b_follows_a_R6: assert property (@(posedge clk) disable iff (rst)
        (b_ph != PH_IDLE) |-> (b_ph == a_ph))
        else $error("storage clocks moved without image clocks");

    assert_fs_single_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start)
        else $error("frame start longer than one cycle");

    assert_fs_cause_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> $past(line_strobe))
        else $error("frame start without line strobe");

    assert_cr_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cr_pulse) |-> $past(line_strobe))
        else $error("charge reset began away from a line strobe");

    assert_still_trigger_R3: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == MODE_STILL) && (a_ph == 4'b0110) && ($past(a_ph) == PH_IDLE))
        |-> $past(blank_win && (blank_phase == PW'(SHIFT_AT))))
        else $error("still shift outside programmed blanking phase");

endmodule

bind ccd_vert_seq vseq_checker #(
    .PW       (PW),
    .SHIFT_AT (SHIFT_AT)
) u_vseq_chk (
    .clk         (clk),
    .rst         (rst),
    .line_strobe (line_strobe),
    .blank_win   (blank_win),
    .blank_phase (blank_phase),
    .a_ph        (a_ph),
    .b_ph        (b_ph),
    .cr_pulse    (cr_pulse),
    .frame_start (frame_start),
    .mode_q      (mode_q)
);

// File: tb/test_ccd_vert_seq.sv
`timescale 1ns/1ps
module test_ccd_vert_seq;

    localparam int E_STILL_LEN = 2035;
    localparam int E_MON_LEN   = 315;
    localparam int E_IMG       = 1324;
    localparam int E_STILL_SH  = 1622;
    localparam int E_HEAD      = 16;
    localparam int E_SUB       = 1290;
    localparam int E_CRW       = 32;
    localparam int E_DIV       = 16;
    localparam int E_Q         = 4;
    localparam int E_AT        = 2;

    typedef struct {
        bit mon;
        int len;
        int a_cnt;
        int b_cnt;
        int sub_kept;
        int cr_at;
        int cr_w;
    } frame_rec_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_strobe = 1'b0;
    logic        blank_win = 1'b0;
    logic [7:0]  blank_phase = '0;
    logic        mode_sel = 1'b0;
    logic [10:0] cr_line = '0;
    logic [3:0]  a_ph, b_ph;
    logic        cr_pulse, frame_start;

    always #4 clk = ~clk;

    ccd_vert_seq i_ccd_vert_seq (
        .clk         (clk),
        .rst         (rst),
        .line_strobe (line_strobe),
        .blank_win   (blank_win),
        .blank_phase (blank_phase),
        .mode_sel    (mode_sel),
        .cr_line     (cr_line),
        .a_ph        (a_ph),
        .b_ph        (b_ph),
        .cr_pulse    (cr_pulse),
        .frame_start (frame_start)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    frame_rec_t exp_q[$];

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_line(input int period);
        for (int c = 0; c < period; c++) begin
            @(posedge clk); #1;
            line_strobe = (c == 0);
            blank_win   = (c >= 3) && (c <= period - 2);
            blank_phase = blank_win ? 8'(c - 3) : 8'd0;
        end
    endtask

    // Monitor state
    bit         open = 0;
    bit         cur_mon = 0;
    int         cyc = 0, lines = 0, a_cnt = 0, b_cnt = 0, sub_kept = 0;
    int         cr_at = -1, cr_w = 0, pat_err = 0, tim_err = 0, wave_err = 0;
    int         last_a = 0, run = 0, closed = 0;
    logic [3:0] a_prev = 4'b0011, b_prev = 4'b0011;
    logic       cr_prev = 1'b0, bw_prev = 1'b0;
    logic [7:0] bp_prev = '0;

    task automatic close_frame();
        frame_rec_t e;
        string tg;
        e = exp_q.pop_front();
        closed++;
        tg = e.mon ? "R5" : "R3";
        check(e.mon ? "R2" : "R8", "frame length", lines, e.len);
        check(tg, "image shifts", a_cnt, e.a_cnt);
        check(e.mon ? "R6" : "R3", "storage shifts", b_cnt, e.b_cnt);
        check("R6", "shifts kept in subsampled region", sub_kept, e.sub_kept);
        check("R7", "charge reset line", cr_at, e.cr_at);
        check("R7", "charge reset width", cr_w, e.cr_w);
        check("R6", "storage step pattern errors", pat_err, 0);
        check(tg, "shift timing errors", tim_err, 0);
        check("R4", "quarter length errors", wave_err, 0);
    endtask

    always @(negedge clk) begin
        bit a_st, b_st, exp_b;
        if (!rst) begin
            cyc++;
            if (line_strobe) lines++;
            if (frame_start) begin
                if (open) close_frame();
                open = 1;
                cur_mon = (exp_q.size() > 0) ? exp_q[0].mon : 1'b0;
                lines = 0; a_cnt = 0; b_cnt = 0; sub_kept = 0; cr_at = -1; cr_w = 0;
                pat_err = 0; tim_err = 0; wave_err = 0;
            end
            a_st = (a_ph == 4'b0110) && (a_prev != 4'b0110);
            b_st = (b_ph == 4'b0110) && (b_prev != 4'b0110);
            if (a_ph != a_prev) begin
                if (a_prev != 4'b0011 && run != E_Q) wave_err++;
                run = 1;
            end else begin
                run++;
            end
            if (a_st) begin
                exp_b = cur_mon ? ((a_cnt < E_HEAD) ||
                                   ((a_cnt < E_HEAD + E_SUB) && (((a_cnt - E_HEAD) % 10) < 2)))
                                : 1'b1;
                if (b_st != exp_b) pat_err++;
                if (b_st && a_cnt >= E_HEAD && a_cnt < E_HEAD + E_SUB) sub_kept++;
                if (!cur_mon) begin
                    if (!(bw_prev && bp_prev == 8'(E_AT))) tim_err++;
                end else if (a_cnt > 0 && (cyc - last_a) != E_DIV) begin
                    tim_err++;
                end
                last_a = cyc;
                a_cnt++;
            end
            if (b_st) b_cnt++;
            if (b_st && !a_st) pat_err++;
            if (cr_pulse && !cr_prev) cr_at = lines;
            if (cr_pulse) cr_w++;
            a_prev = a_ph; b_prev = b_ph; cr_prev = cr_pulse;
            bw_prev = blank_win; bp_prev = blank_phase;
        end
    end

    initial begin
        frame_rec_t r;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1", "image phases in reset", int'(a_ph), 4'b0011);
        check("R1", "storage phases in reset", int'(b_ph), 4'b0011);
        @(posedge clk); #1; rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "image phases after reset", int'(a_ph), 4'b0011);
        check("R1", "storage phases after reset", int'(b_ph), 4'b0011);
        check("R1", "charge reset after reset", int'(cr_pulse), 0);
        check("R1", "frame start after reset", int'(frame_start), 0);

        // Frame 0: still; mode and CR line change mid-frame (R8)
        mode_sel = 1'b0; cr_line = 11'd5;
        r = '{mon: 0, len: E_STILL_LEN, a_cnt: E_STILL_SH, b_cnt: E_STILL_SH,
              sub_kept: E_SUB, cr_at: 5, cr_w: E_CRW};
        exp_q.push_back(r);
        for (int l = 0; l < 100; l++) drive_line(24);
        mode_sel = 1'b1; cr_line = 11'd20;
        for (int l = 100; l < E_STILL_LEN; l++) drive_line(24);

        // Frame 1: monitor
        r = '{mon: 1, len: E_MON_LEN, a_cnt: E_IMG, b_cnt: E_HEAD + 258,
              sub_kept: 258, cr_at: 20, cr_w: E_CRW};
        exp_q.push_back(r);
        for (int l = 0; l < E_MON_LEN; l++) drive_line(80);

        // Frame 2: monitor; inputs change mid-frame and must be ignored (R8)
        exp_q.push_back(r);
        for (int l = 0; l < 50; l++) drive_line(80);
        mode_sel = 1'b0; cr_line = 11'd7;
        for (int l = 50; l < E_MON_LEN; l++) drive_line(80);

        drive_line(24);
        repeat (4) @(negedge clk);
        check("R2", "frames closed", closed, 3);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", closed, 3);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule